// File: doc/BRIEF.md
# Wakeup-Bit Message Serial Transmitter

This block sends bytes on an asynchronous serial line for a multidrop bus on which every character carries a ninth marker bit. The marker tells the listening devices that a new message begins. A host hands over bytes through a valid/ready handshake. Each byte comes with a start-of-message flag. The flag is copied into the ninth bit of that character, so the first byte of a message goes out with the marker set and every later byte goes out with it clear. This works for any data value, because the ninth bit never depends on the data.

Bit timing comes from a divider that counts `baud_div` clock cycles per bit. A byte that is waiting when the current character ends starts on the very next bit boundary, so consecutive bytes of a message need no idle time between them. After each character the block counts idle cycles. If a continuation byte (flag clear) arrives after more idle cycles than `gap_limit`, the block raises a sticky violation flag. That byte is still sent normally.

Top module: `wakeup_msg_tx`

## Requirements
- R1: After reset, and whenever no character is in flight, `txd` is 1, `busy` is 0, `in_ready` is 1 and `gap_violation` is 0 until a violation occurs.
- R2: Each character is 11 bits, each bit lasting `baud_div` clock cycles, in this order on `txd`: a start bit at 0, then the eight data bits least significant first, then the ninth (marker) bit, then a stop bit at 1.
- R3: The ninth bit equals the `in_som` value sampled with the accepted byte (1 for a message's first byte, 0 otherwise), for every data value including 0x00, 0x01, 0x80, 0x81, 0x82 and 0xFF.
- R4: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. While a character is in flight, `in_ready` is 0 except in the final clock cycle of its stop bit.
- R5: A byte accepted in the final stop-bit cycle puts its start bit on `txd` in the very next cycle, with zero idle cycles between the two characters.
- R6: `busy` is 1 from the cycle after a byte is accepted until the last cycle of the last queued character's stop bit.
- R7: When a byte with `in_som` = 0 is accepted after more than `gap_limit` idle cycles since the previous character's stop bit ended, `gap_violation` becomes 1 in the next cycle, and that byte is still transmitted correctly.
- R8: `gap_violation` is not raised for a byte with `in_som` = 1, for the first byte after reset, or for a continuation byte whose idle gap is at most `gap_limit` cycles.
- R9: Once raised, `gap_violation` stays 1 until a cycle with `gap_clear` = 1, after which it reads 0. A new violation in the same cycle as `gap_clear` keeps the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clock cycles per bit (at least 1) |
| gap_limit | input | GAP_W | Largest allowed idle gap inside a message, in cycles |
| in_valid | input | 1 | Host offers a byte |
| in_data | input | DATA_W | Byte to send |
| in_som | input | 1 | Byte is the first of a message (sets ninth bit) |
| in_ready | output | 1 | Block takes the offered byte on this edge |
| gap_clear | input | 1 | Clears the sticky gap flag |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A character is in flight |
| gap_violation | output | 1 | Sticky flag: a continuation byte came too late |

## Verification
The assertions assume that `baud_div` is at least 1 and does not change while a character is in flight, and that `gap_limit` does not change during an idle gap that is being measured. The bench changes both only while the line is idle and no byte is offered. It always uses a divisor of 4 or 6 and a fixed gap limit of 12. Idle gaps are set by waiting a known number of cycles after `busy` falls, so the expected flag state follows from that count alone.

// File: rtl/wkb_pkg.sv
package wkb_pkg;
  // start bit + ninth marker bit + stop bit around the data
  localparam int FRAME_OVERHEAD = 3;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/wk_baud_gen.sv
module wk_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    tick   = run && (cnt_q == div - DIV_W'(1));
    cnt_en = run || (cnt_q != '0);
    if (!run || restart || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: the bit counter never passes the divisor while running
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div));
endmodule

// File: rtl/wk_frame_shift.sv
module wk_frame_shift
  import wkb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_wake,
  input  logic              tick,
  output logic              txd,
  output logic              busy,
  output logic              frame_end
);
  localparam int FRAME_W  = DATA_W + FRAME_OVERHEAD;
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int LAST_IDX = FRAME_W - 1;

  tx_state_e          st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               upd_en;

  assign busy      = (st_q == TX_SEND);
  assign frame_end = busy && tick && (idx_q == IDX_W'(LAST_IDX));
  assign txd       = busy ? sh_q[0] : 1'b1;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    upd_en = load || (busy && tick);
    if (load) begin
      st_d  = TX_SEND;
      sh_d  = {1'b1, load_wake, load_data, 1'b0};
      idx_d = '0;
    end else if (busy && tick) begin
      sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
      idx_d = idx_q + IDX_W'(1);
      if (frame_end) st_d = TX_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      sh_q  <= '1;
      idx_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  // R2: a loaded character opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (txd == 1'b0));
  // R2: the final bit of a character is the high stop bit
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (txd == 1'b1));
  // R6: busy follows every load
  a_r6_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
endmodule

// File: rtl/wk_gap_mon.sv
module wk_gap_mon #(
  parameter int GAP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic             busy,
  input  logic             accept,
  input  logic             accept_som,
  input  logic [GAP_W-1:0] gap_limit,
  input  logic             gap_clear,
  output logic             gap_violation
);
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             flag_q, flag_d;
  logic             late;

  always_comb begin
    cnt_d = cnt_q;
    if (busy)                   cnt_d = '0;
    else if (cnt_q < gap_limit) cnt_d = cnt_q + GAP_W'(1);
    armed_d = armed_q | frame_end;
    late    = accept && !accept_som && armed_q && !busy && (cnt_q >= gap_limit);
    flag_d  = late | (flag_q & ~gap_clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      flag_q  <= flag_d;
    end
  end

  assign gap_violation = flag_q;

  // R9: flag holds until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_violation && !gap_clear) |=> gap_violation);
  // R8: a message-start byte never raises the flag
  a_r8_som_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!gap_violation && accept && accept_som) |=> !gap_violation);
endmodule

// File: rtl/wakeup_msg_tx.sv
module wakeup_msg_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int GAP_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [GAP_W-1:0]  gap_limit,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_som,
  output logic              in_ready,
  input  logic              gap_clear,
  output logic              txd,
  output logic              busy,
  output logic              gap_violation
);
  logic tick;
  logic frame_end;
  logic accept;

  assign in_ready = !busy || frame_end;
  assign accept   = in_valid && in_ready;

  wk_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .restart (accept),
    .div     (baud_div),
    .tick    (tick)
  );

  wk_frame_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (in_data),
    .load_wake (in_som),
    .tick      (tick),
    .txd       (txd),
    .busy      (busy),
    .frame_end (frame_end)
  );

  wk_gap_mon #(.GAP_W(GAP_W)) u_gap (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_end     (frame_end),
    .busy          (busy),
    .accept        (accept),
    .accept_som    (in_som),
    .gap_limit     (gap_limit),
    .gap_clear     (gap_clear),
    .gap_violation (gap_violation)
  );

  // R1: the line rests high whenever nothing is in flight
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R5: a byte waiting at the stop-bit end starts with no idle cycle
  a_r5_zero_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && in_valid) |=> (busy && !txd));
endmodule

// File: tb/wakeup_msg_tx_bench.sv
module wakeup_msg_tx_bench;
  localparam int LIMIT = 12;

  typedef struct packed {
    logic [7:0] d;
    logic       som;
    logic       b2b;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] baud_div;
  logic [23:0] gap_limit;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_som;
  logic        in_ready;
  logic        gap_clear;
  logic        txd;
  logic        busy;
  logic        gap_violation;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  int    last_end = 0;
  bit    have_prev = 0;
  bit    exp_flag = 0;
  item_t q[$];

  wakeup_msg_tx u_wakeup_msg_tx (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .gap_limit(gap_limit),
    .in_valid(in_valid), .in_data(in_data), .in_som(in_som), .in_ready(in_ready),
    .gap_clear(gap_clear), .txd(txd), .busy(busy), .gap_violation(gap_violation)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: k idle cycles are waited after busy drops unless b2b
  task automatic send(input logic [7:0] d, input logic som, input bit b2b, input int k);
    item_t it;
    @(negedge clk);
    if (!b2b) begin
      while (busy) @(negedge clk);
      repeat (k) @(negedge clk);
    end
    in_valid = 1'b1;
    in_data  = d;
    in_som   = som;
    while (!in_ready) @(negedge clk);
    it.d = d; it.som = som; it.b2b = b2b;
    q.push_back(it);
    if (!b2b && !som && have_prev && (k + 1) > LIMIT) exp_flag = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    have_prev = 1'b1;
    chk(busy == 1'b1, "R6", "busy after accept", int'(busy), 1);
    chk(gap_violation == exp_flag, exp_flag ? "R7" : "R8", "gap flag after accept",
        int'(gap_violation), int'(exp_flag));
  endtask

  task automatic clear_flag();
    @(negedge clk);
    gap_clear = 1'b1;
    @(negedge clk);
    gap_clear = 1'b0;
    exp_flag = 1'b0;
    chk(gap_violation == 1'b0, "R9", "flag after clear", int'(gap_violation), 0);
  endtask

  // monitor: decodes each character and compares with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        automatic int         dv = int'(baud_div);
        automatic int         st = cyc;
        automatic logic [7:0] got = '0;
        automatic logic       wk;
        automatic item_t      it;
        repeat (dv / 2) @(negedge clk);
        chk(txd == 1'b0, "R2", "start bit", int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
          repeat (dv) @(negedge clk);
          got[i] = txd;
        end
        repeat (dv) @(negedge clk);
        wk = txd;
        repeat (dv) @(negedge clk);
        chk(txd == 1'b1, "R2", "stop bit", int'(txd), 1);
        if (q.size() == 0) begin
          chk(1'b0, "R2", "unexpected character", int'(got), -1);
        end else begin
          it = q.pop_front();
          chk(got == it.d, "R2", "data bits", int'(got), int'(it.d));
          chk(wk == it.som, "R3", "ninth bit", int'(wk), int'(it.som));
          if (it.b2b)
            chk(st == last_end, "R5", "back-to-back start cycle", st, last_end);
        end
        last_end = st + 11 * dv;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_som = 1'b0; gap_clear = 1'b0;
    baud_div = 16'd4; gap_limit = 24'(LIMIT);
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(in_ready == 1'b1, "R1", "reset ready", int'(in_ready), 1);
    chk(gap_violation == 1'b0, "R1", "reset flag", int'(gap_violation), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // first byte, then the ready window at the stop bit end (R4)
    send(8'h81, 1'b1, 1'b0, 0);
    repeat (11 * 4 - 2) @(negedge clk);
    chk(in_ready == 1'b0, "R4", "ready before last stop cycle", int'(in_ready), 0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R4", "ready in last stop cycle", int'(in_ready), 1);
    @(negedge clk);
    chk(busy == 1'b0 && txd == 1'b1, "R1", "idle after frame", int'(busy), 0);

    // message with back-to-back continuation bytes
    send(8'h00, 1'b1, 1'b0, 3);
    send(8'h55, 1'b0, 1'b1, 0);
    send(8'hA3, 1'b0, 1'b1, 0);

    // marker bit set with awkward data values
    send(8'h01, 1'b1, 1'b0, 2);
    send(8'h80, 1'b1, 1'b0, 0);
    send(8'h82, 1'b1, 1'b0, 5);
    send(8'hFF, 1'b1, 1'b0, 0);

    // gap boundary: exactly the limit, then one over
    send(8'h3C, 1'b0, 1'b0, LIMIT - 1);
    send(8'hC3, 1'b0, 1'b0, LIMIT);
    send(8'h7E, 1'b0, 1'b0, 0);
    chk(gap_violation == 1'b1, "R9", "flag sticky", int'(gap_violation), 1);
    clear_flag();
    send(8'hE7, 1'b1, 1'b0, 40);

    // slower divisor
    @(negedge clk);
    while (busy) @(negedge clk);
    baud_div = 16'd6;
    send(8'h96, 1'b1, 1'b0, 0);
    send(8'h69, 1'b0, 1'b1, 0);
    send(8'hF0, 1'b0, 1'b0, LIMIT + 3);
    clear_flag();

    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0, "R1", "final idle", int'(txd), 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule